// File: doc/BRIEF.md
# Serial Echo Output for a Chainable Shift Register

This block produces the serial data output of a 16-bit command shift register. Every bit shifted in on the serial data input pushes the oldest bit toward the output, so the word written in one chip-select frame is shifted back out during the next frame. A host can read back what it wrote, and several devices can be chained by feeding one device's output into the next device's input.

The edge that moves the output is selectable. With the mode input at 0, the output changes on falling serial-clock edges. With the mode input at 1, it changes on rising serial-clock edges. Mode 0 therefore trails the input by half a serial-clock cycle more than mode 1. The mode comes from a command controller outside this block and is captured once per frame.

All serial inputs are sampled by a fast system clock, and serial-clock edges are found by edge detection. An active-low clear empties the register and drives the output low.

Top module: `dse_echo_out`

## Requirements
- R1: After `rstN` is released, or while `clrN` is low, `dout` is 0, the shift register holds all zeros and the captured mode is 0. The next frame then echoes 16'h0000.
- R2: A bit is taken from `din` only on a rising `sclk` edge seen while `csN` is low. It enters at bit 0 and moves one place toward bit 15 on each later rising edge.
- R3: The word shifted in during one 16-clock frame is sent back on `dout` during the next frame, most significant bit first. Just before rising edge k (k = 1..16) of that frame, `dout` carries bit 16-k of the word.
- R4: In mode 0 (`modeSel` = 0), `dout` keeps its value across a rising `sclk` edge. After the falling edge that follows, `dout` takes the new bit 15 of the register.
- R5: In mode 1 (`modeSel` = 1), `dout` takes the new bit 15 right after each rising `sclk` edge. It keeps its value across falling edges.
- R6: While `csN` is high, `sclk` and `din` activity changes neither `dout` nor the stored word.
- R7: The mode is taken from `modeSel` when `csN` falls. A change of `modeSel` within a frame has no effect until the next frame starts.
- R8: An output update follows the serial-clock edge that causes it within three `clk` cycles.
- R9: When two instances share `sclk`, `csN` and `modeSel`, and the second one's `din` is the first one's `dout`, the word written to the first instance in frame N is echoed by the second instance in frame N+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| clrN | input | 1 | Synchronous active-low clear of register, mode and output |
| sclk | input | 1 | Serial clock |
| csN | input | 1 | Active-low chip select that frames words |
| din | input | 1 | Serial data input |
| modeSel | input | 1 | Output-edge select: 0 = falling, 1 = rising |
| dout | output | 1 | Serial echo output |

## Verification
The testbench sends words in both modes and checks `dout` after every serial-clock phase. Mode 0 and mode 1 differ only in which phase moves the output, so each phase check tells the two modes apart. The directed words are all-zero, all-one, alternating patterns and single set bits at either end, which catch shift-direction and end-bit mistakes. Seeded random words with a random mode on each frame cover mode changes between frames. Stray clocks with chip select high, a mid-frame flip of the mode input, and a clear are each followed by a frame whose echo shows whether the stored word or the mode was disturbed. A second chained instance confirms that the echo arrives at the right time to be used as input by the next device.

// File: rtl/dse_pkg.sv
package dse_pkg;
  localparam int WORD_W_DEF = 16;

  typedef struct packed {
    logic shift;    // rising serial edge inside a frame
    logic loadOut;  // update the output bit
    logic clear;    // synchronous clear request
  } dseStrobe_t;
endpackage

// File: rtl/dse_ctrl.sv
module dse_ctrl
  import dse_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       din,
  input  logic       modeSel,
  output dseStrobe_t strobes,
  output logic       dinS,
  output logic       modeAct
);
  logic sclkQ, sclkQQ, csQ, csQQ, modeQ;
  logic rise, fall, frameStart, modeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      sclkQQ <= 1'b0;
      csQ    <= 1'b1;
      csQQ   <= 1'b1;
      dinS   <= 1'b0;
      modeQ  <= 1'b0;
    end else begin
      sclkQ  <= sclk;
      sclkQQ <= sclkQ;
      csQ    <= csN;
      csQQ   <= csQ;
      dinS   <= din;
      modeQ  <= modeSel;
    end
  end

  assign frameStart = csQQ & ~csQ;
  assign modeNow    = frameStart ? modeQ : modeAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           modeAct <= 1'b0;
    else if (!clrN)      modeAct <= 1'b0;
    else if (frameStart) modeAct <= modeQ;
  end

  assign rise = sclkQ & ~sclkQQ & ~csQ;
  assign fall = ~sclkQ & sclkQQ & ~csQ;

  always_comb begin
    strobes.clear   = ~clrN;
    strobes.shift   = rise;
    strobes.loadOut = modeNow ? rise : fall;
  end
endmodule

// File: rtl/dse_shift.sv
module dse_shift
  import dse_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dseStrobe_t        strobes,
  input  logic              dinS,
  output logic [WORD_W-1:0] srWord,
  output logic              dout
);
  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] srNext;

  assign srNext = strobes.shift ? {srWord[MSB-1:0], dinS} : srWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srWord <= '0;
      dout   <= 1'b0;
    end else if (strobes.clear) begin
      srWord <= '0;
      dout   <= 1'b0;
    end else begin
      srWord <= srNext;
      if (strobes.loadOut) dout <= srNext[MSB];
    end
  end
endmodule

// File: rtl/dse_echo_out.sv
module dse_echo_out
  import dse_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic clk,
  input  logic rstN,
  input  logic clrN,
  input  logic sclk,
  input  logic csN,
  input  logic din,
  input  logic modeSel,
  output logic dout
);
  dseStrobe_t        strobes;
  logic              dinS;
  logic              modeAct;
  logic [WORD_W-1:0] srWord;

  dse_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sclk(sclk), .csN(csN),
    .din(din), .modeSel(modeSel), .strobes(strobes), .dinS(dinS),
    .modeAct(modeAct)
  );

  dse_shift #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dinS(dinS),
    .srWord(srWord), .dout(dout)
  );
endmodule

// File: rtl/dse_echo_chk.sv
module dse_echo_chk
  import dse_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrN,
  input logic              csN,
  input logic              dout,
  input dseStrobe_t        strobes,
  input logic              modeAct,
  input logic [WORD_W-1:0] srWord
);
  AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> (dout == 1'b0) && (srWord == '0));  // R1
  AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> !modeAct);  // R1
  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !strobes.clear) |=> srWord[WORD_W-1:1] == $past(srWord[WORD_W-2:0]));  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && clrN) |=> ($stable(dout) && $stable(srWord)));  // R6
  AST_MODE_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && !$past(csN, 2) && clrN) |=> $stable(modeAct));  // R7
endmodule

bind dse_echo_out dse_echo_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .clrN(clrN), .csN(csN), .dout(dout),
  .strobes(strobes), .modeAct(modeAct), .srWord(srWord)
);

// File: tb/dse_echo_out_tb_top.sv
`timescale 1ns/1ps
module dse_echo_out_tb_top;
  logic clk = 1'b0;
  logic rstN, clrN, sclk, csN, din, modeSel;
  logic dout1, dout2;
  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  logic [15:0] srM;
  logic        expDout;
  logic        modeF;
  logic [15:0] exp2Next;

  always #2 clk = ~clk;

  dse_echo_out dut_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sclk(sclk), .csN(csN),
    .din(din), .modeSel(modeSel), .dout(dout1)
  );

  dse_echo_out dut2_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sclk(sclk), .csN(csN),
    .din(dout1), .modeSel(modeSel), .dout(dout2)
  );

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic waitPhase();
    repeat (4) @(negedge clk);  // covers the R8 latency bound
  endtask

  // Mode taken at frame start; bits shift in at LSB on rises (R2).
  task automatic frame(input logic [15:0] w, input logic m, input bit flip);
    logic [15:0] echo1, echo2, exp1, exp2;
    string tag;
    exp1 = srM;
    exp2 = exp2Next;
    modeSel = m;
    csN = 1'b0;
    modeF = m;
    tag = flip ? "R7" : (m ? "R5" : "R4");
    waitPhase();
    for (int i = 0; i < 16; i++) begin
      din = w[15-i];
      waitPhase();
      echo1[15-i] = dout1;
      echo2[15-i] = dout2;
      chk({tag, " before rise"}, {15'd0, dout1}, {15'd0, expDout});
      if (flip && i == 8) modeSel = ~m;
      sclk = 1'b1;
      srM = {srM[14:0], w[15-i]};
      if (modeF) expDout = srM[15];
      waitPhase();
      chk({tag, " after rise"}, {15'd0, dout1}, {15'd0, expDout});
      sclk = 1'b0;
      if (!modeF) expDout = srM[15];
      waitPhase();
      chk({tag, " after fall"}, {15'd0, dout1}, {15'd0, expDout});
    end
    csN = 1'b1;
    waitPhase();
    chk("R2 R3 echo", echo1, exp1);
    chk("R9 chained echo", echo2, exp2);
    exp2Next = exp1;
  endtask

  task automatic idleClocks(input int n);
    logic d0;
    d0 = dout1;
    for (int i = 0; i < n; i++) begin
      din = $urandom_range(0, 1);
      sclk = 1'b1;
      waitPhase();
      sclk = 1'b0;
      waitPhase();
      chk("R6 idle hold", {15'd0, dout1}, {15'd0, d0});
    end
  endtask

  task automatic doClear();
    clrN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 clear dout", {15'd0, dout1}, 16'd0);
    chk("R1 clear chained dout", {15'd0, dout2}, 16'd0);
    clrN = 1'b1;
    srM = '0;
    expDout = 1'b0;
    exp2Next = '0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd5253));
    rstN = 1'b0; clrN = 1'b1; sclk = 1'b0; csN = 1'b1; din = 1'b0; modeSel = 1'b0;
    srM = '0; expDout = 1'b0; modeF = 1'b0; exp2Next = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset dout", {15'd0, dout1}, 16'd0);
    chk("R1 reset chained dout", {15'd0, dout2}, 16'd0);

    // Directed patterns in both modes
    frame(16'h0000, 1'b0, 0);
    frame(16'hFFFF, 1'b0, 0);
    frame(16'hA5C3, 1'b0, 0);
    frame(16'h5A3C, 1'b1, 0);
    frame(16'h8001, 1'b1, 0);
    frame(16'h7FFE, 1'b0, 0);

    // R6: stray clocks while deselected, then echo shows the word held
    idleClocks(6);
    frame(16'h0F0F, 1'b1, 0);

    // R7: mode input flipped mid-frame
    frame(16'h1234, 1'b0, 1);
    frame(16'hCAFE, 1'b1, 1);
    frame(16'h0001, 1'b0, 0);

    // R1: clear, then the next echo must be zero
    doClear();
    frame(16'h9669, 1'b1, 0);
    frame(16'h3C3C, 1'b0, 0);

    // Seeded random words and modes
    for (int k = 0; k < 24; k++) begin
      frame(16'($urandom()), 1'($urandom_range(0, 1)), 0);
    end
    frame(16'h0000, 1'b0, 0);
    finishRun();
  end
endmodule